// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block runs one external memory access at a time on behalf of a processor core. When the core raises a request while it holds the bus, the block decodes the upper address bits into one of four attribute areas. It then drives that area's chip-select and holds the cycle open for the number of wait states programmed for the area. An active-low acknowledge input can stretch the cycle beyond that programmed minimum. When the cycle ends, the block drops the chip-selects and raises a one-cycle done pulse.

A 24-bit control register holds the per-area minimum wait counts, a count for addresses that hit no area, and a bit that turns off the one-hot priority encoding of the chip-selects. A separate mode input chooses how acknowledge is used. It is either taken straight from the pin as a synchronous signal, or passed through a two-flop synchronizer first. The synchronizer adds two cycles of latency before a change on the pin can end a cycle. A build parameter can add one trailing wait state whenever the selected count lies between 3 and 7.

Top module: `xbus_wait_ctrl`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), cs_o is 4'b0000 and done_o is 0. The control register reads as all zero, which means every count is zero and priority mode is on.
- R2: In priority mode, bit i of addr_hi marks area i. The lowest-numbered marked area wins, and only its cs_o bit is asserted (cs_o is one-hot) while the access runs.
- R3: If addr_hi is 4'b0000, the access uses the default count in control bits 20..16 and leaves cs_o at 4'b0000 for the whole access.
- R4: The minimum wait counts sit in these control bits: area 0 in 4..0, area 1 in 9..5, area 2 in 12..10 and area 3 in 15..13. Bit 23 set turns priority mode off.
- R5: A request is accepted at a clock edge. With acknowledge asserted and minimum count W (after R11), cs_o stays asserted for exactly W+1 cycles. done_o is high for exactly one cycle, the cycle right after the last chip-select cycle.
- R6: When W is at least 1, the cycle ends at the first edge at which the remaining count is zero and the effective acknowledge is asserted. Holding acknowledge high (deasserted) therefore stretches the cycle without limit, and the length is the larger of W+1 and the acknowledge-driven length.
- R7: An access whose selected count is zero lasts exactly one cycle, whatever the level of ack_n.
- R8: With ack_sync high, ack_n passes through two flops before use. A fall of ack_n that is seen at the end of stalled cycle k ends the access after cycle k+2. With ack_sync low, the same fall ends it after cycle k.
- R9: With bit 23 set, cs_o equals addr_hi for the whole access. The wait count still comes from the lowest marked area.
- R10: cs_o is 4'b0000 whenever no access is in progress, and always in the done cycle. Back-to-back requests therefore always see at least one cycle with no chip-select asserted.
- R11: With EXTRA_TRAIL set (the default), a selected count from 3 to 7 inclusive gives one more wait state (W = count+1). Other counts are used as they are.
- R12: While mstr is low, requests are not accepted and acknowledge is ignored. cs_o and done_o stay at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Writes cfg_wdata into the control register |
| cfg_wdata | input | 24 | Control register write data |
| req | input | 1 | Access request from the core |
| addr_hi | input | 4 | Upper address bits; bit i marks area i |
| mstr | input | 1 | High while this block owns the external bus |
| ack_n | input | 1 | Transfer acknowledge, active low |
| ack_sync | input | 1 | 1: acknowledge goes through the internal synchronizer |
| cs_o | output | 4 | Area chip-selects, active high |
| done_o | output | 1 | One-cycle pulse after an access ends |

## Verification
Two events can fall in the same cycle: the expiry of the programmed minimum and the arrival of acknowledge. The bench releases acknowledge exactly in the cycle the count reaches zero, and again one cycle later. It checks that the first case ends on the minimum and the second case ends one cycle longer. A second collision is the done cycle of one access meeting the request of the next. The bench holds the request high across two accesses and checks that cs_o drops for exactly that cycle before the next chip-select appears. A cycle-level reference model is compared on every clock in all of these cases.

// File: rtl/xbwc_pkg.sv
// Package: shared constants and field helpers for the wait-state controller.
// Assumes a fixed 24-bit control register with four attribute areas.
package xbwc_pkg;
    localparam int NUM_AREAS = 4;
    localparam int CFG_W     = 24;
    localparam int FIELD_W   = 5;
    localparam int CNT_W     = FIELD_W + 1;
    localparam int IDX_W     = $clog2(NUM_AREAS);
    localparam int DFLT_LO   = 16;
    localparam int PDIS_BIT  = 23;

    // Low bit of the wait field for area i.
    function automatic int fld_lo(input int i);
        case (i)
            0:       return 0;
            1:       return 5;
            2:       return 10;
            default: return 13;
        endcase
    endfunction

    // Mask of valid bits in the wait field for area i.
    function automatic logic [FIELD_W-1:0] fld_mask(input int i);
        return (i >= 2) ? FIELD_W'(7) : FIELD_W'(31);
    endfunction
endpackage

// File: rtl/xbwc_area_dec.sv
// Area decoder: picks the lowest marked area and its minimum wait count,
// and forms the chip-select code. Purely combinational.
// Assumes addr_hi bit i marks area i; no mark selects the default count.
module xbwc_area_dec
    import xbwc_pkg::*;
(
    input  logic [NUM_AREAS-1:0] attr,
    input  logic [CFG_W-1:0]     cfg,
    output logic [FIELD_W-1:0]   wait_sel,
    output logic [NUM_AREAS-1:0] cs_code
);
    logic             hit;
    logic [IDX_W-1:0] idx;
    logic [CFG_W-1:0] shifted;

    // Priority search: the lowest set bit wins, because the loop runs downward.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NUM_AREAS - 1; i >= 0; i--) begin
            if (attr[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    // Pull out the wait field of the winning area, or the default field.
    always_comb begin
        if (hit) begin
            shifted  = cfg >> fld_lo(int'(idx));
            wait_sel = shifted[FIELD_W-1:0] & fld_mask(int'(idx));
        end else begin
            shifted  = cfg >> DFLT_LO;
            wait_sel = shifted[FIELD_W-1:0];
        end
    end

    // Chip-select code: the raw attribute bits, or one-hot on the winner.
    always_comb begin
        if (cfg[PDIS_BIT])
            cs_code = attr;
        else if (hit)
            cs_code = NUM_AREAS'(1) << idx;
        else
            cs_code = '0;
    end
endmodule

// File: rtl/xbwc_ack_path.sv
// Acknowledge path: either the raw synchronous input or a two-flop
// synchronized copy, chosen by sync_sel. Output is active high.
// Assumes ack_n idles high (deasserted); the flops reset to that level.
module xbwc_ack_path #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n,
    input  logic sync_sel,
    output logic ack_ok
);
    logic [SYNC_STAGES-1:0] chain;

    // Shift the pin level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain <= '1;
        else
            chain <= {chain[SYNC_STAGES-2:0], ack_n};
    end

    // Choose between the direct and the synchronized level.
    always_comb begin
        ack_ok = sync_sel ? !chain[SYNC_STAGES-1] : !ack_n;
    end
endmodule

// File: rtl/xbwc_seq.sv
// Access sequencer: loads the minimum count at start, counts it down,
// then waits for acknowledge (unless the count was zero), drops the
// chip-selects and pulses done. Assumes start only arrives while idle.
module xbwc_seq
    import xbwc_pkg::*;
#(
    parameter bit EXTRA_TRAIL = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [FIELD_W-1:0]   start_wait,
    input  logic [NUM_AREAS-1:0] start_cs,
    input  logic                 start_pdis,
    input  logic                 ack_hit,
    output logic                 busy,
    output logic                 zw,
    output logic                 pdis,
    output logic [CNT_W-1:0]     cnt,
    output logic [NUM_AREAS-1:0] cs,
    output logic                 done
);
    logic trail;

    generate
        if (EXTRA_TRAIL) begin : g_trail
            assign trail = (start_wait >= FIELD_W'(3)) && (start_wait <= FIELD_W'(7));
        end else begin : g_no_trail
            assign trail = 1'b0;
        end
    endgenerate

    // Run one access: load, count down, then wait for acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            zw   <= 1'b0;
            pdis <= 1'b0;
            cnt  <= '0;
            cs   <= '0;
            done <= 1'b0;
        end else if (start) begin
            busy <= 1'b1;
            zw   <= (start_wait == '0);
            pdis <= start_pdis;
            cnt  <= CNT_W'(start_wait) + CNT_W'(trail);
            cs   <= start_cs;
            done <= 1'b0;
        end else if (busy) begin
            if (cnt != '0) begin
                cnt  <= cnt - CNT_W'(1);
                done <= 1'b0;
            end else if (zw || ack_hit) begin
                busy <= 1'b0;
                cs   <= '0;
                done <= 1'b1;
            end else begin
                done <= 1'b0;
            end
        end else begin
            done <= 1'b0;
        end
    end
endmodule

// File: rtl/xbus_wait_ctrl.sv
// External bus wait-state controller top. Holds the control register,
// decodes the area, routes acknowledge and runs one access at a time.
// Assumes the core keeps addr_hi stable during the request cycle only.
module xbus_wait_ctrl
    import xbwc_pkg::*;
#(
    parameter bit EXTRA_TRAIL = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 req,
    input  logic [NUM_AREAS-1:0] addr_hi,
    input  logic                 mstr,
    input  logic                 ack_n,
    input  logic                 ack_sync,
    output logic [NUM_AREAS-1:0] cs_o,
    output logic                 done_o
);
    logic [CFG_W-1:0]     cfg_q;
    logic [FIELD_W-1:0]   wait_sel;
    logic [NUM_AREAS-1:0] cs_code;
    logic                 ack_ok;
    logic                 seq_busy;
    logic                 seq_zw;
    logic                 seq_pdis;
    logic [CNT_W-1:0]     seq_cnt;
    logic                 start;
    logic                 cfg_unused;

    assign cfg_unused = ^cfg_q[PDIS_BIT-1:DFLT_LO+FIELD_W];

    // Control register: written as a whole and cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (cfg_wr)
            cfg_q <= cfg_wdata;
    end

    // Accept a request only while idle and holding the bus.
    always_comb begin
        start = req && mstr && !seq_busy;
    end

    xbwc_area_dec i_dec (
        .attr     (addr_hi),
        .cfg      (cfg_q),
        .wait_sel (wait_sel),
        .cs_code  (cs_code)
    );

    xbwc_ack_path #(.SYNC_STAGES(SYNC_STAGES)) i_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_n    (ack_n),
        .sync_sel (ack_sync),
        .ack_ok   (ack_ok)
    );

    xbwc_seq #(.EXTRA_TRAIL(EXTRA_TRAIL)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_wait (wait_sel),
        .start_cs   (cs_code),
        .start_pdis (cfg_q[PDIS_BIT]),
        .ack_hit    (ack_ok && mstr),
        .busy       (seq_busy),
        .zw         (seq_zw),
        .pdis       (seq_pdis),
        .cnt        (seq_cnt),
        .cs         (cs_o),
        .done       (done_o)
    );
endmodule

// File: rtl/xbwc_checker.sv
// Checker: temporal properties of the wait-state controller, bound to the top.
module xbwc_checker
    import xbwc_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req,
    input logic                 mstr,
    input logic [NUM_AREAS-1:0] cs_o,
    input logic                 done_o,
    input logic                 busy,
    input logic                 zw,
    input logic                 pdis,
    input logic [CNT_W-1:0]     cnt
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (cs_o == '0 && !done_o));

    assert_prio_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pdis) |-> $onehot0(cs_o));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_zero_wait_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && zw && cnt == '0) |=> done_o);

    assert_cs_clear_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> cs_o == '0);

    assert_cs_clear_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_o == '0);

    assert_no_start_unowned_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req && !mstr) |=> !busy);
endmodule

bind xbus_wait_ctrl xbwc_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .mstr   (mstr),
    .cs_o   (cs_o),
    .done_o (done_o),
    .busy   (seq_busy),
    .zw     (seq_zw),
    .pdis   (seq_pdis),
    .cnt    (seq_cnt)
);

// File: tb/test_xbus_wait_ctrl.sv
// Bench: directed accesses with hand-computed lengths plus a behavioural
// cycle model compared on every clock.
module test_xbus_wait_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [23:0] cfg_wdata = '0;
    logic        req = 1'b0;
    logic [3:0]  addr_hi = '0;
    logic        mstr = 1'b1;
    logic        ack_n = 1'b1;
    logic        ack_sync = 1'b0;
    logic [3:0]  cs_o;
    logic        done_o;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    string ctag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_wait_ctrl i_xbus_wait_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .req(req), .addr_hi(addr_hi), .mstr(mstr), .ack_n(ack_n),
        .ack_sync(ack_sync), .cs_o(cs_o), .done_o(done_o)
    );

    // ---------------- behavioural reference model ----------------
    int          m_busy, m_rem, m_zero, m_done;
    logic [3:0]  m_cs;
    logic [23:0] m_cfg;
    bit          ack_hist[$];

    function automatic int pick_wait(logic [23:0] c, logic [3:0] a);
        if (a[0]) return int'(c[4:0]);
        if (a[1]) return int'(c[9:5]);
        if (a[2]) return int'(c[12:10]);
        if (a[3]) return int'(c[15:13]);
        return int'(c[20:16]);
    endfunction

    function automatic logic [3:0] pick_cs(logic [23:0] c, logic [3:0] a);
        if (c[23]) return a;
        if (a[0]) return 4'b0001;
        if (a[1]) return 4'b0010;
        if (a[2]) return 4'b0100;
        if (a[3]) return 4'b1000;
        return 4'b0000;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_rem = 0; m_zero = 0; m_done = 0; m_cs = '0; m_cfg = '0;
            ack_hist = '{1'b1, 1'b1};
        end else begin
            bit ok;
            ok = ack_sync ? !ack_hist[0] : !ack_n;
            ok = ok && mstr;
            if (!m_busy && req && mstr) begin
                int w;
                w = pick_wait(m_cfg, addr_hi);
                m_zero = (w == 0);
                if (w >= 3 && w <= 7) w = w + 1;
                m_rem = w; m_busy = 1; m_cs = pick_cs(m_cfg, addr_hi); m_done = 0;
            end else if (m_busy) begin
                if (m_rem > 0) begin
                    m_rem--; m_done = 0;
                end else if (m_zero || ok) begin
                    m_busy = 0; m_cs = '0; m_done = 1;
                end else m_done = 0;
            end else m_done = 0;
            void'(ack_hist.pop_front());
            ack_hist.push_back(ack_n);
            if (cfg_wr) m_cfg = cfg_wdata;
        end
    end

    // Compare against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (cs_o !== m_cs || done_o !== 1'(m_done)) begin
                fails++;
                $display("FAIL %s model cs=%b done=%b expected cs=%b done=%0d",
                         ctag, cs_o, done_o, m_cs, m_done);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check_int(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_cfg(logic [23:0] v);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic set_ack(logic lvl);
        ack_n = lvl;
        repeat (3) @(negedge clk);
    endtask

    // Issue one access; release ack at chip-select cycle k_rel (0: never).
    task automatic do_access(string tag, logic [3:0] a, int k_rel,
                             int exp_len, logic [3:0] exp_cs);
        int n;
        logic [3:0] seen;
        ctag = tag;
        @(negedge clk); req = 1'b1; addr_hi = a;
        @(negedge clk); req = 1'b0;
        n = 1;
        seen = cs_o;
        while (!done_o && n < 300) begin
            if (n == k_rel) ack_n = 1'b0;
            @(negedge clk);
            n++;
        end
        check_int(tag, n - 1, exp_len);
        check_int(tag, int'(seen), int'(exp_cs));
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [23:0] base;
        repeat (3) @(negedge clk);
        check_int("R1", int'(cs_o), 0);
        check_int("R1", int'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset config is all-zero counts with priority mode on.
        do_access("R1", 4'b0011, 0, 1, 4'b0001);

        base = 24'd2 | (24'd5 << 5) | (24'd0 << 10) | (24'd7 << 13) | (24'd1 << 16);
        write_cfg(base);
        set_ack(1'b0);
        do_access("R4", 4'b0001, 0, 3, 4'b0001);        // R5: W=2 -> 3
        do_access("R11", 4'b0010, 0, 7, 4'b0010);       // 5 -> 6 waits
        do_access("R11", 4'b1000, 0, 9, 4'b1000);       // 7 -> 8 waits
        do_access("R3", 4'b0000, 0, 2, 4'b0000);
        do_access("R2", 4'b0110, 0, 7, 4'b0010);
        do_access("R2", 4'b1100, 0, 1, 4'b0100);

        set_ack(1'b1);
        do_access("R7", 4'b0100, 0, 1, 4'b0100);        // zero wait ignores ack
        set_ack(1'b1);
        do_access("R6", 4'b0000, 4, 4, 4'b0000);        // stretched past W+1=2
        set_ack(1'b1);
        do_access("R6", 4'b1000, 9, 9, 4'b1000);        // ack lands on expiry
        set_ack(1'b1);
        do_access("R6", 4'b1000, 10, 10, 4'b1000);      // one cycle later

        ack_sync = 1'b1;
        set_ack(1'b0);
        do_access("R8", 4'b0001, 0, 3, 4'b0001);
        set_ack(1'b1);
        do_access("R8", 4'b0000, 4, 6, 4'b0000);
        ack_sync = 1'b0;

        write_cfg(base | 24'h800000);
        set_ack(1'b0);
        do_access("R9", 4'b1010, 0, 7, 4'b1010);

        // R10: back-to-back requests leave a cycle without chip-select.
        ctag = "R10";
        @(negedge clk); req = 1'b1; addr_hi = 4'b0001;
        @(negedge clk);
        while (!done_o) @(negedge clk);
        check_int("R10", int'(cs_o), 0);
        @(negedge clk);
        check_int("R10", int'(cs_o), 1);
        req = 1'b0;
        while (!done_o) @(negedge clk);
        @(negedge clk);

        // R12: no acceptance while the bus is not owned.
        ctag = "R12";
        mstr = 1'b0; req = 1'b1; addr_hi = 4'b0001;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check_int("R12", int'(cs_o) + int'(done_o), 0);
        end
        req = 1'b0; mstr = 1'b1;
        repeat (2) @(negedge clk);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            checks++;
            $display("FAIL %s watchdog actual=hung expected=complete", ctag);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule